// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block sits behind a 16-bit host register port and holds the settings for four 12-bit digital-to-analog converter channels. Each channel owns a staging data word and a live data word. A host write fills a staging word, and the live words only take the staged values when the host reads a dedicated data-commit address. All four channels therefore switch on the same clock edge.

The per-channel polarity and gain selections are staged the same way. A second read address commits them. In that control word the fields are packed in reverse channel order: channel n's bipolar bit sits at bit 7-n and its high-gain bit at bit 11-n. A mode register holds a global enable and a buffered-mode select. With buffering off, a data write reaches its channel's live output directly. With the enable clear, every output presented to the converters is forced to zero. A one-cycle load pulse marks every edge on which the live data words are loaded.

Top module: `dacbank_top`

## Requirements
- R1: After a synchronous reset the mode register, the staged and live control words and all staged and live data words are zero, and `dac_load` is low. After reset, enabling the block and committing both words still yields zero codes, polarity and gain.
- R2: While mode bit 1 (enable) is 0, `dac_code`, `dac_bipolar` and `dac_gain` are all zero. The live values return unchanged once the bit is set again.
- R3: With mode bit 0 (buffered) set, a write to a data address (byte offset 0x14 + 2n for channel n) leaves the live codes unchanged. A host read of offset 0x02 copies all four staged words to the live codes on one edge.
- R4: With mode bit 0 clear, a data write updates that channel's live code on the next edge and leaves the other channels unchanged.
- R5: Only bits 11:0 of a data write are kept.
- R6: A write to offset 0x12 changes no output until a host read of offset 0x12. Then channel n takes bipolar from bit 7-n and high gain from bit 11-n of the staged word. Channel 0 is the least significant bit of `dac_bipolar` and `dac_gain`.
- R7: A read of 0x02 leaves polarity and gain unchanged, and a read of 0x12 leaves the codes unchanged.
- R8: `dac_load` is high for exactly the one cycle after each edge that loads the live data words (a 0x02 read, or an unbuffered data write). The live codes do not change in any other cycle.
- R9: Writes to unmapped offsets, and reads of any offset other than 0x02 and 0x12, change no output and raise no load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_addr | input | AW (6) | Byte offset of the access |
| host_wdata | input | HW (16) | Write data |
| dac_code | output | NCH*DW (48) | Live codes, channel n at bits n*DW +: DW |
| dac_bipolar | output | NCH (4) | Live bipolar select per channel |
| dac_gain | output | NCH (4) | Live high-gain select per channel |
| dac_load | output | 1 | One-cycle pulse when live codes load |

## Verification
The bench builds the block with its defaults: four channels, 12-bit codes, a 16-bit host word and a 6-bit offset. Four channels make every reversed field position reachable, so channel 3 lands on bits 4 and 8. The 12-bit width lets a full 16-bit write show the dropped top nibble. One vector walk crosses both modes, so buffered holding, direct writes, both commit reads and the enable mask all act on the same live state. A later reset confirms that every staged word was cleared, not only the live ones.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int NCH_DEF = 4;
    localparam int DW_DEF  = 12;
    localparam int HW_DEF  = 16;
    localparam int AW_DEF  = 6;

    // Byte offsets on the host port
    localparam logic [AW_DEF-1:0] OFS_MODE   = 6'h02;
    localparam logic [AW_DEF-1:0] OFS_RANGE  = 6'h12;
    localparam logic [AW_DEF-1:0] OFS_DATA0  = 6'h14;

    // Mode register bits
    localparam int MODE_EN_BIT  = 1;
    localparam int MODE_BUF_BIT = 0;

    // Range word: channel n fields sit at BASE - n
    localparam int POL_TOP  = 7;
    localparam int GAIN_TOP = 11;

    typedef struct packed {
        logic enable;
        logic buffered;
    } mode_t;

    typedef struct packed {
        logic wr_mode;
        logic wr_range;
        logic rd_range;
        logic rd_data;
    } strobe_t;

    function automatic logic [AW_DEF-1:0] data_ofs(input int n);
        return OFS_DATA0 + AW_DEF'(2 * n);
    endfunction

endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int AW  = AW_DEF
) (
    input  logic                 wr,
    input  logic                 rd,
    input  logic [AW-1:0]        addr,
    output strobe_t              stb,
    output logic [NCH-1:0]       wr_chan
);

    always_comb begin
        stb.wr_mode  = wr && (addr == AW'(OFS_MODE));
        stb.wr_range = wr && (addr == AW'(OFS_RANGE));
        stb.rd_range = rd && (addr == AW'(OFS_RANGE));
        stb.rd_data  = rd && (addr == AW'(OFS_MODE));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan_dec
        assign wr_chan[n] = wr && (addr == AW'(data_ofs(n)));
    end

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stage_we,
    input  logic [DW-1:0] stage_din,
    input  logic          direct,
    input  logic          commit,
    output logic [DW-1:0] live
);

    logic [DW-1:0] staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (stage_we) begin
            staged <= stage_din;
        end
    end

    // A direct write wins over a commit in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (stage_we && direct) begin
            live <= stage_din;
        end else if (commit) begin
            live <= staged;
        end
    end

endmodule

// File: rtl/dacbank_range.sv
module dacbank_range
    import dacbank_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int HW  = HW_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [HW-1:0]  din,
    input  logic           commit,
    output logic [NCH-1:0] bipolar,
    output logic [NCH-1:0] gain
);

    logic [HW-1:0] staged_word;
    logic [HW-1:0] live_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_word <= '0;
            live_word   <= '0;
        end else begin
            if (wr) begin
                staged_word <= din;
            end
            if (commit) begin
                live_word <= staged_word;
            end
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_fields
        assign bipolar[n] = live_word[POL_TOP - n];
        assign gain[n]    = live_word[GAIN_TOP - n];
    end

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int DW  = DW_DEF,
    parameter int HW  = HW_DEF,
    parameter int AW  = AW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [AW-1:0]     host_addr,
    input  logic [HW-1:0]     host_wdata,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH-1:0]    dac_bipolar,
    output logic [NCH-1:0]    dac_gain,
    output logic              dac_load
);

    localparam int CODE_W = NCH * DW;

    strobe_t           stb;
    logic [NCH-1:0]    wr_chan;
    mode_t             mode_q;
    logic [CODE_W-1:0] live_flat;
    logic [NCH-1:0]    live_pol;
    logic [NCH-1:0]    live_gain;
    logic              load_now;

    dacbank_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .wr      (host_wr),
        .rd      (host_rd),
        .addr    (host_addr),
        .stb     (stb),
        .wr_chan (wr_chan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (stb.wr_mode) begin
            mode_q.enable   <= host_wdata[MODE_EN_BIT];
            mode_q.buffered <= host_wdata[MODE_BUF_BIT];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dacbank_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .stage_we  (wr_chan[n]),
            .stage_din (host_wdata[DW-1:0]),
            .direct    (!mode_q.buffered),
            .commit    (stb.rd_data),
            .live      (live_flat[n*DW +: DW])
        );
        assign dac_code[n*DW +: DW] = mode_q.enable ? live_flat[n*DW +: DW] : '0;
    end

    dacbank_range #(.NCH(NCH), .HW(HW)) u_range (
        .clk     (clk),
        .rst     (rst),
        .wr      (stb.wr_range),
        .din     (host_wdata),
        .commit  (stb.rd_range),
        .bipolar (live_pol),
        .gain    (live_gain)
    );

    assign dac_bipolar = mode_q.enable ? live_pol  : '0;
    assign dac_gain    = mode_q.enable ? live_gain : '0;

    assign load_now = stb.rd_data || ((|wr_chan) && !mode_q.buffered);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_load <= 1'b0;
        end else begin
            dac_load <= load_now;
        end
    end

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
    import dacbank_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int DW  = DW_DEF,
    parameter int AW  = AW_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [AW-1:0]     host_addr,
    input logic [NCH*DW-1:0] dac_code,
    input logic [NCH-1:0]    dac_bipolar,
    input logic [NCH-1:0]    dac_gain,
    input logic              dac_load,
    input logic              en_q,
    input logic              buf_q,
    input logic [NCH*DW-1:0] live_flat,
    input logic [NCH-1:0]    live_pol,
    input logic [NCH-1:0]    live_gain
);

    logic is_data_addr;
    assign is_data_addr = (host_addr >= AW'(OFS_DATA0))
                       && (host_addr < AW'(OFS_DATA0) + AW'(2 * NCH))
                       && !host_addr[0];

    a_r8_live_moves_with_load: assert property (@(posedge clk) disable iff (rst)
        !dac_load |-> $stable(live_flat));

    a_r3_buffered_write_no_load: assert property (@(posedge clk) disable iff (rst)
        (host_wr && buf_q && !host_rd) |=> !dac_load);

    a_r4_direct_write_loads: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !buf_q && is_data_addr) |=> dac_load);

    a_r6_range_waits_commit: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_addr == AW'(OFS_RANGE)) |=> ($stable(live_pol) && $stable(live_gain)));

    a_r2_disabled_outputs_zero: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (dac_code == '0 && dac_bipolar == '0 && dac_gain == '0));

endmodule

bind dacbank_top dacbank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .dac_code    (dac_code),
    .dac_bipolar (dac_bipolar),
    .dac_gain    (dac_gain),
    .dac_load    (dac_load),
    .en_q        (mode_q.enable),
    .buf_q       (mode_q.buffered),
    .live_flat   (live_flat),
    .live_pol    (live_pol),
    .live_gain   (live_gain)
);

// File: tb/tb_dacbank_top.sv
module tb_dacbank_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [47:0] dac_code;
    logic [3:0]  dac_bipolar;
    logic [3:0]  dac_gain;
    logic        dac_load;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacbank_top dut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .dac_code    (dac_code),
        .dac_bipolar (dac_bipolar),
        .dac_gain    (dac_gain),
        .dac_load    (dac_load)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        rd;
        logic [5:0]  addr;
        logic [15:0] data;
        logic [47:0] code;
        logic [3:0]  bip;
        logic [3:0]  gain;
        logic        load;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 1'b0, 6'h02, 16'h0003, 48'h0,            4'h0, 4'h0, 1'b0}, // R2 enable+buffered
        '{8'd3, 1'b0, 6'h14, 16'h0ABC, 48'h0,            4'h0, 4'h0, 1'b0}, // R3 staged only
        '{8'd5, 1'b0, 6'h16, 16'hF123, 48'h0,            4'h0, 4'h0, 1'b0}, // R5 top nibble dropped later
        '{8'd3, 1'b0, 6'h18, 16'h0456, 48'h0,            4'h0, 4'h0, 1'b0}, // R3
        '{8'd3, 1'b0, 6'h1A, 16'h0789, 48'h0,            4'h0, 4'h0, 1'b0}, // R3
        '{8'd7, 1'b1, 6'h12, 16'h0000, 48'h0,            4'h0, 4'h0, 1'b0}, // R7 range read keeps codes
        '{8'd3, 1'b1, 6'h02, 16'h0000, 48'h789456123ABC, 4'h0, 4'h0, 1'b1}, // R3 R5 all at once
        '{8'd6, 1'b0, 6'h12, 16'h0A50, 48'h789456123ABC, 4'h0, 4'h0, 1'b0}, // R6 staged only
        '{8'd7, 1'b1, 6'h02, 16'h0000, 48'h789456123ABC, 4'h0, 4'h0, 1'b1}, // R7 data read keeps range
        '{8'd6, 1'b1, 6'h12, 16'h0000, 48'h789456123ABC, 4'hA, 4'h5, 1'b0}, // R6 reversed fields
        '{8'd9, 1'b0, 6'h04, 16'hFFFF, 48'h789456123ABC, 4'hA, 4'h5, 1'b0}, // R9 unmapped write
        '{8'd4, 1'b0, 6'h02, 16'h0002, 48'h789456123ABC, 4'hA, 4'h5, 1'b0}, // R4 direct mode
        '{8'd4, 1'b0, 6'h16, 16'h0FFF, 48'h789456FFFABC, 4'hA, 4'h5, 1'b1}, // R4 ch1 only
        '{8'd4, 1'b0, 6'h1A, 16'h0001, 48'h001456FFFABC, 4'hA, 4'h5, 1'b1}, // R4 ch3 only
        '{8'd9, 1'b1, 6'h00, 16'h0000, 48'h001456FFFABC, 4'hA, 4'h5, 1'b0}, // R9 other read
        '{8'd2, 1'b0, 6'h02, 16'h0000, 48'h0,            4'h0, 4'h0, 1'b0}, // R2 masked
        '{8'd2, 1'b0, 6'h02, 16'h0002, 48'h001456FFFABC, 4'hA, 4'h5, 1'b0}  // R2 restored
    };

    task automatic check(input int req, input logic [47:0] ec, input logic [3:0] eb,
                         input logic [3:0] eg, input logic el);
        tests++;
        if (dac_code !== ec || dac_bipolar !== eb || dac_gain !== eg || dac_load !== el) begin
            fails++;
            $display("FAIL R%0d: code=%h bip=%h gain=%h load=%b expected code=%h bip=%h gain=%h load=%b",
                     req, dac_code, dac_bipolar, dac_gain, dac_load, ec, eb, eg, el);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic host_op(input logic rd, input logic [5:0] a, input logic [15:0] d);
        host_wr    = !rd;
        host_rd    = rd;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(1, 48'h0, 4'h0, 4'h0, 1'b0); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            host_op(VEC[i].rd, VEC[i].addr, VEC[i].data);
            check(int'(VEC[i].req), VEC[i].code, VEC[i].bip, VEC[i].gain, VEC[i].load);
        end

        // R8: idle cycle after a load drops the pulse, codes hold
        @(negedge clk);
        check(8, 48'h001456FFFABC, 4'hA, 4'h5, 1'b0);

        // R9: reading a data address commits nothing
        host_op(1'b1, 6'h14, 16'h0);
        check(9, 48'h001456FFFABC, 4'hA, 4'h5, 1'b0);

        // R1: reset mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, 48'h0, 4'h0, 4'h0, 1'b0);

        // R1: enable shows cleared live words
        host_op(1'b0, 6'h02, 16'h0003);
        check(1, 48'h0, 4'h0, 4'h0, 1'b0);

        // R1: staged range word was cleared
        host_op(1'b1, 6'h12, 16'h0);
        check(1, 48'h0, 4'h0, 4'h0, 1'b0);

        // R1: staged data words were cleared
        host_op(1'b1, 6'h02, 16'h0);
        check(1, 48'h0, 4'h0, 4'h0, 1'b1);

        // R5: full-width write in buffered mode, then commit
        host_op(1'b0, 6'h14, 16'hFFFF);
        check(5, 48'h0, 4'h0, 4'h0, 1'b0);
        host_op(1'b1, 6'h02, 16'h0);
        check(5, 48'h000000000FFF, 4'h0, 4'h0, 1'b1);

        // R8: pulse lasts one cycle
        @(negedge clk);
        check(8, 48'h000000000FFF, 4'h0, 4'h0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule